// File: doc/BRIEF.md
# Match/Capture Timer Counter

A general-purpose timer/counter with a word-addressed register file. A counter of up to 32 bits advances either once per wrap of a programmable prescale divider or once per chosen edge of one of the external capture inputs. Four compare slots watch the count. On a hit, each slot can flag an interrupt, send the count back to zero, or halt counting, in any combination. Each slot also owns an output pin that it can leave alone, pull low, pull high or invert.

Two capture channels copy the live count into their own registers on a rising edge, a falling edge or both, and may flag an interrupt when they do. Every interrupt source has its own sticky flag. Software clears a flag by writing a one to it, and a single interrupt line carries the OR of all flags. Capture inputs pass through a two-stage synchroniser before their edges are detected. The block sits behind a simple valid/ready bus that is always ready. Read data comes back one cycle after the request.

Top module: `mct_timer`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `ext_out` and the counter are low. `bus_ready` is always 1.
- R2: With control bit 0 (run) set, control bit 1 (hold) clear and source mode 0, the prescale counter steps 0,1,…,PSC and then returns to 0. The count rises by one on each of these returns, so it gains one every PSC+1 clocks. With run clear, the count does not move.
- R3: While hold is set, the count and the prescale counter are forced to zero, whatever the run bit and the input edges.
- R4: Slot n owns match-control bits [3n+2:3n]. Bit 3n+1 sends the count to zero at the step where it equals the slot's compare value. With compare value V the count cycles 0..V.
- R5: Bit 3n+2 of match control halts counting at a hit: the run bit reads back 0 and the count keeps the compare value.
- R6: Bit 3n of match control sets interrupt flag n at a hit. Without that bit no flag is set. `irq` is high while any flag is set.
- R7: Writing the interrupt word clears each flag whose data bit is 1 and leaves flags written with 0 unchanged.
- R8: The output word holds the pin levels in bits [3:0] and the action of slot n in bits [5+2n:4+2n]. The action codes are 0 keep, 1 low, 2 high, 3 invert. The pin levels change only at a hit or on a write to that word.
- R9: Capture channel n owns capture-control bits [3n+2:3n]. Bit 3n captures on a rising edge and bit 3n+1 on a falling edge. A capture copies the count into that channel's register. An edge whose bit is clear is ignored.
- R10: Capture-control bit 3n+2 sets interrupt flag 4+n on a capture of channel n.
- R11: In source mode 1, 2 or 3 (source word bits [1:0]), the count gains exactly one per rising, falling or either edge of the capture input chosen by source bit 2. The prescaler plays no part, and the other input is ignored.
- R12: Word map: 0 flags, 1 control, 2 count, 3 prescale limit, 4 prescale counter, 5 match control, 6–9 compare values, 10 capture control, 11–12 capture registers, 13 output word, 14 source word. Other words read 0. Writes to the count and capture words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request valid |
| bus_ready | output | 1 | Bus request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | BUS_W | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | BUS_W | Read data |
| cap_in | input | N_CAP | Asynchronous capture / count inputs |
| ext_out | output | N_MATCH | Match-driven output pins |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The counting path is driven in three ways. A clock-driven run with a non-zero prescale checks the divide ratio. A run with reset-on-match checks that the count wraps at the compare value and does not step past it. Edge-driven runs count pulses on one input while the other input also toggles. The stop, reset and output actions are spread over several slots in a single run. Reading the halted count and the pin levels afterwards shows which slot acted and in what order. The capture checks apply each edge polarity to each channel, so a channel that responds to the wrong polarity is caught.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;
   // fixed word indices at the low end of the map
   localparam int IDX_IRQ    = 0;
   localparam int IDX_CTRL   = 1;
   localparam int IDX_COUNT  = 2;
   localparam int IDX_PSC    = 3;
   localparam int IDX_PSCNT  = 4;
   localparam int IDX_MCTL   = 5;
   localparam int IDX_MATCH0 = 6;

   typedef enum logic [1:0] {
      EXT_KEEP = 2'd0,
      EXT_LOW  = 2'd1,
      EXT_HIGH = 2'd2,
      EXT_FLIP = 2'd3
   } ext_act_e;

   typedef enum logic [1:0] {
      SRC_CLK  = 2'd0,
      SRC_RISE = 2'd1,
      SRC_FALL = 2'd2,
      SRC_BOTH = 2'd3
   } cnt_src_e;

   typedef struct packed {
      logic stop;
      logic clr;
      logic irq;
   } match_ctl_t;
endpackage

// File: rtl/mct_edge_sync.sv
`timescale 1ns/1ps
module mct_edge_sync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mct_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/mct_prescale.sv
`timescale 1ns/1ps
module mct_prescale #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         hold,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         wrap
);
   // >= so that lowering the limit below the current count wraps at once
   assign wrap = run & ~hold & (count >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= '0;
      else if (hold)    count <= '0;
      else if (wrap)    count <= '0;
      else if (run)     count <= count + W'(1);
   end
endmodule

// File: rtl/mct_match_slot.sv
`timescale 1ns/1ps
module mct_match_slot
   import mct_pkg::*;
#(
   parameter int W = 32
)(
   input  logic         tick,
   input  logic [W-1:0] count,
   input  logic [W-1:0] limit,
   input  match_ctl_t   ctl,
   input  ext_act_e     ext_act,
   input  logic         lvl,
   output logic         evt,
   output logic         irq_set,
   output logic         clr_req,
   output logic         stop_req,
   output logic         lvl_nxt
);
   assign evt      = tick & (count == limit);
   assign irq_set  = evt & ctl.irq;
   assign clr_req  = evt & ctl.clr;
   assign stop_req = evt & ctl.stop;

   always_comb begin
      lvl_nxt = lvl;
      if (evt) begin
         case (ext_act)
            EXT_LOW:  lvl_nxt = 1'b0;
            EXT_HIGH: lvl_nxt = 1'b1;
            EXT_FLIP: lvl_nxt = ~lvl;
            default:  lvl_nxt = lvl;
         endcase
      end
   end
endmodule

// File: rtl/mct_timer.sv
`timescale 1ns/1ps
module mct_timer
   import mct_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int N_MATCH     = 4,
   parameter int N_CAP       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int BUS_W       = 32,
   parameter int ADDR_W      = 5
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_valid,
   output logic               bus_ready,
   input  logic               bus_write,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic               bus_rvalid,
   output logic [BUS_W-1:0]   bus_rdata,
   input  logic [N_CAP-1:0]   cap_in,
   output logic [N_MATCH-1:0] ext_out,
   output logic               irq
);
   localparam int N_SRC       = N_MATCH + N_CAP;
   localparam int SEL_W       = (N_CAP > 1) ? $clog2(N_CAP) : 1;
   localparam int IDX_CCTL    = IDX_MATCH0 + N_MATCH;
   localparam int IDX_CAP0    = IDX_CCTL + 1;
   localparam int IDX_EXT     = IDX_CAP0 + N_CAP;
   localparam int IDX_MODE    = IDX_EXT + 1;
   localparam int EXT_ACT_LSB = N_MATCH;

   if (CNT_W < 1 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("mct_timer: CNT_W must be 1..BUS_W");
   end
   if (N_MATCH < 1 || 3 * N_MATCH > BUS_W) begin : g_bad_match
      $error("mct_timer: N_MATCH fields do not fit the bus word");
   end
   if (N_CAP < 1 || 3 * N_CAP > BUS_W) begin : g_bad_cap
      $error("mct_timer: N_CAP fields do not fit the bus word");
   end
   if (N_SRC > BUS_W || 2 + SEL_W > BUS_W) begin : g_bad_src
      $error("mct_timer: flag or source word too wide");
   end
   if (IDX_MODE >= (1 << ADDR_W)) begin : g_bad_addr
      $error("mct_timer: ADDR_W too small for the word map");
   end

   // ---------------- register state ----------------
   logic                     en_q, hold_q;
   logic [CNT_W-1:0]         count_q;
   logic [CNT_W-1:0]         psc_q;
   logic [3*N_MATCH-1:0]     mctl_q;
   logic [CNT_W-1:0]         match_q [N_MATCH];
   logic [3*N_CAP-1:0]       cctl_q;
   logic [CNT_W-1:0]         cap_q   [N_CAP];
   logic [2*N_MATCH-1:0]     ext_act_q;
   logic [N_MATCH-1:0]       ext_lvl_q;
   cnt_src_e                 mode_q;
   logic [SEL_W-1:0]         sel_q;
   logic [N_SRC-1:0]         flags_q;

   // ---------------- write strobes ----------------
   logic wr_en, rd_en;
   logic wr_irq, wr_ctrl, wr_psc, wr_mctl, wr_cctl, wr_ext, wr_mode;

   assign bus_ready = 1'b1;
   assign wr_en   = bus_valid &  bus_write;
   assign rd_en   = bus_valid & ~bus_write;
   assign wr_irq  = wr_en && (bus_addr == ADDR_W'(IDX_IRQ));
   assign wr_ctrl = wr_en && (bus_addr == ADDR_W'(IDX_CTRL));
   assign wr_psc  = wr_en && (bus_addr == ADDR_W'(IDX_PSC));
   assign wr_mctl = wr_en && (bus_addr == ADDR_W'(IDX_MCTL));
   assign wr_cctl = wr_en && (bus_addr == ADDR_W'(IDX_CCTL));
   assign wr_ext  = wr_en && (bus_addr == ADDR_W'(IDX_EXT));
   assign wr_mode = wr_en && (bus_addr == ADDR_W'(IDX_MODE));

   // ---------------- input edges ----------------
   logic [N_CAP-1:0] cap_rise, cap_fall, cap_evt, cap_irq;
   logic             sel_rise, sel_fall;

   for (genvar c = 0; c < N_CAP; c++) begin : g_cap
      mct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (cap_in[c]),
         .rise (cap_rise[c]),
         .fall (cap_fall[c])
      );
      assign cap_evt[c] = (cctl_q[3*c]   & cap_rise[c]) |
                          (cctl_q[3*c+1] & cap_fall[c]);
      assign cap_irq[c] = cap_evt[c] & cctl_q[3*c+2];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cap_q[c] <= '0;
         else if (cap_evt[c]) cap_q[c] <= count_q;
      end
   end

   always_comb begin
      sel_rise = 1'b0;
      sel_fall = 1'b0;
      for (int k = 0; k < N_CAP; k++) begin
         if (sel_q == SEL_W'(k)) begin
            sel_rise = cap_rise[k];
            sel_fall = cap_fall[k];
         end
      end
   end

   // ---------------- tick source ----------------
   logic run, psc_wrap, tick;
   logic [CNT_W-1:0] pscnt;

   assign run = en_q & ~hold_q;

   mct_prescale #(.W(CNT_W)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (en_q && (mode_q == SRC_CLK)),
      .hold (hold_q),
      .limit(psc_q),
      .count(pscnt),
      .wrap (psc_wrap)
   );

   always_comb begin
      case (mode_q)
         SRC_CLK:  tick = psc_wrap;
         SRC_RISE: tick = run & sel_rise;
         SRC_FALL: tick = run & sel_fall;
         default:  tick = run & (sel_rise | sel_fall);
      endcase
   end

   // ---------------- compare slots ----------------
   logic [N_MATCH-1:0] m_evt, m_irq, m_clr, m_stop, m_lvl;
   logic               clr_any, stop_any;

   for (genvar m = 0; m < N_MATCH; m++) begin : g_match
      mct_match_slot #(.W(CNT_W)) u_slot (
         .tick    (tick),
         .count   (count_q),
         .limit   (match_q[m]),
         .ctl     (match_ctl_t'(mctl_q[3*m +: 3])),
         .ext_act (ext_act_e'(ext_act_q[2*m +: 2])),
         .lvl     (ext_lvl_q[m]),
         .evt     (m_evt[m]),
         .irq_set (m_irq[m]),
         .clr_req (m_clr[m]),
         .stop_req(m_stop[m]),
         .lvl_nxt (m_lvl[m])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            match_q[m] <= '0;
         else if (wr_en && (bus_addr == ADDR_W'(IDX_MATCH0 + m)))
            match_q[m] <= bus_wdata[CNT_W-1:0];
      end
   end

   assign clr_any  = |m_clr;
   assign stop_any = |m_stop;

   // ---------------- counter and control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (hold_q) begin
         count_q <= '0;
      end else if (tick) begin
         if (clr_any)        count_q <= '0;
         else if (!stop_any) count_q <= count_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         hold_q    <= 1'b0;
         psc_q     <= '0;
         mctl_q    <= '0;
         cctl_q    <= '0;
         ext_act_q <= '0;
         ext_lvl_q <= '0;
         mode_q    <= SRC_CLK;
         sel_q     <= '0;
         flags_q   <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q   <= bus_wdata[0];
            hold_q <= bus_wdata[1];
         end
         if (stop_any) en_q <= 1'b0;
         if (wr_psc)  psc_q  <= bus_wdata[CNT_W-1:0];
         if (wr_mctl) mctl_q <= bus_wdata[3*N_MATCH-1:0];
         if (wr_cctl) cctl_q <= bus_wdata[3*N_CAP-1:0];
         if (wr_mode) begin
            mode_q <= cnt_src_e'(bus_wdata[1:0]);
            sel_q  <= bus_wdata[2 +: SEL_W];
         end
         if (wr_ext) begin
            ext_lvl_q <= bus_wdata[N_MATCH-1:0];
            ext_act_q <= bus_wdata[EXT_ACT_LSB +: 2*N_MATCH];
         end else begin
            ext_lvl_q <= m_lvl;
         end
         // set wins over a same-cycle clear
         flags_q <= (flags_q & ~(wr_irq ? bus_wdata[N_SRC-1:0] : '0))
                    | {cap_irq, m_irq};
      end
   end

   assign ext_out = ext_lvl_q;
   assign irq     = |flags_q;

   // ---------------- read path ----------------
   logic [BUS_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (bus_addr == ADDR_W'(IDX_IRQ))   rd_mux[N_SRC-1:0]     = flags_q;
      if (bus_addr == ADDR_W'(IDX_CTRL))  rd_mux[1:0]           = {hold_q, en_q};
      if (bus_addr == ADDR_W'(IDX_COUNT)) rd_mux[CNT_W-1:0]     = count_q;
      if (bus_addr == ADDR_W'(IDX_PSC))   rd_mux[CNT_W-1:0]     = psc_q;
      if (bus_addr == ADDR_W'(IDX_PSCNT)) rd_mux[CNT_W-1:0]     = pscnt;
      if (bus_addr == ADDR_W'(IDX_MCTL))  rd_mux[3*N_MATCH-1:0] = mctl_q;
      if (bus_addr == ADDR_W'(IDX_CCTL))  rd_mux[3*N_CAP-1:0]   = cctl_q;
      if (bus_addr == ADDR_W'(IDX_EXT)) begin
         rd_mux[N_MATCH-1:0]               = ext_lvl_q;
         rd_mux[EXT_ACT_LSB +: 2*N_MATCH]  = ext_act_q;
      end
      if (bus_addr == ADDR_W'(IDX_MODE)) begin
         rd_mux[1:0]       = mode_q;
         rd_mux[2 +: SEL_W] = sel_q;
      end
      for (int k = 0; k < N_MATCH; k++)
         if (bus_addr == ADDR_W'(IDX_MATCH0 + k)) rd_mux[CNT_W-1:0] = match_q[k];
      for (int k = 0; k < N_CAP; k++)
         if (bus_addr == ADDR_W'(IDX_CAP0 + k))   rd_mux[CNT_W-1:0] = cap_q[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= rd_en;
         if (rd_en) bus_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/mct_timer_chk.sv
`timescale 1ns/1ps
module mct_timer_chk #(
   parameter int CNT_W   = 32,
   parameter int N_MATCH = 4,
   parameter int N_CAP   = 2
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 hold,
   input logic                 en,
   input logic                 tick,
   input logic                 stop_any,
   input logic [CNT_W-1:0]     count,
   input logic [3*N_CAP-1:0]   cctl,
   input logic [N_CAP-1:0]     cap_evt,
   input logic [N_MATCH+N_CAP-1:0] flags,
   input logic [N_MATCH-1:0]   m_evt,
   input logic                 ext_write,
   input logic [N_MATCH-1:0]   ext_lvl
);
   // R2: the count only holds, steps by one, or returns to zero
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1))
               || (count == '0));

   // R2: without run and hold the count does not move
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !hold) |=> $stable(count));

   // R3: hold forces the count to zero
   p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (count == '0));

   // R5: a stop hit drops the run bit
   p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && stop_any) |=> !en);

   // R8: pin levels move only on a hit or a write
   p_ext_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|m_evt) && !ext_write) |=> $stable(ext_lvl));

   // R10: an enabled capture sets its flag
   for (genvar c = 0; c < N_CAP; c++) begin : g_cf
      p_cap_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_evt[c] && cctl[3*c+2]) |=> flags[N_MATCH+c]);
   end
endmodule

bind mct_timer mct_timer_chk #(
   .CNT_W  (CNT_W),
   .N_MATCH(N_MATCH),
   .N_CAP  (N_CAP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hold     (hold_q),
   .en       (en_q),
   .tick     (tick),
   .stop_any (stop_any),
   .count    (count_q),
   .cctl     (cctl_q),
   .cap_evt  (cap_evt),
   .flags    (flags_q),
   .m_evt    (m_evt),
   .ext_write(wr_ext),
   .ext_lvl  (ext_lvl_q)
);

// File: tb/tb_mct_timer.sv
`timescale 1ns/1ps
module tb_mct_timer;
   import mct_pkg::*;

   localparam int CNT_W   = 32;
   localparam int N_MATCH = 4;
   localparam int N_CAP   = 2;
   localparam int BUS_W   = 32;
   localparam int ADDR_W  = 5;
   localparam int I_CCTL  = 10;
   localparam int I_CAP0  = 11;
   localparam int I_CAP1  = 12;
   localparam int I_EXT   = 13;
   localparam int I_MODE  = 14;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               bus_valid = 1'b0;
   logic               bus_ready;
   logic               bus_write = 1'b0;
   logic [ADDR_W-1:0]  bus_addr  = '0;
   logic [BUS_W-1:0]   bus_wdata = '0;
   logic               bus_rvalid;
   logic [BUS_W-1:0]   bus_rdata;
   logic [N_CAP-1:0]   cap_in = '0;
   logic [N_MATCH-1:0] ext_out;
   logic               irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   mct_timer #(
      .CNT_W(CNT_W), .N_MATCH(N_MATCH), .N_CAP(N_CAP),
      .SYNC_STAGES(2), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .cap_in(cap_in), .ext_out(ext_out), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(int idx, logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1;
      bus_addr  = ADDR_W'(idx); bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   // driver: queue the expectation, then issue the read
   task automatic bus_rd(int idx, logic [31:0] exp, string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ADDR_W'(idx);
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(int c);
      cap_in[c] = 1'b1; idle(5);
      cap_in[c] = 1'b0; idle(5);
   endtask

   // monitor: pop and compare each returned read
   always @(negedge clk) begin
      if (bus_rvalid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R12: unexpected read data 0x%0h expected none", bus_rdata);
         end else begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      idle(5);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 ext_out", 32'(ext_out), 0);
      chk("R1 ready", 32'(bus_ready), 1);
      bus_rd(IDX_COUNT, 0, "R1 count");
      bus_rd(IDX_IRQ,   0, "R1 flags");
      bus_rd(IDX_CTRL,  0, "R1 ctrl");
      bus_rd(I_EXT,     0, "R1 ext word");

      // R2 prescaled counting: PSC=3 -> +1 per 4 clocks, 21 clocks -> 5
      bus_wr(IDX_PSC, 3);
      bus_wr(IDX_CTRL, 1);
      idle(21);
      bus_rd(IDX_COUNT, 5, "R2 prescaled count");

      // R3 hold zeroes count and prescale counter
      bus_wr(IDX_CTRL, 2);
      idle(2);
      bus_rd(IDX_COUNT, 0, "R3 count under hold");
      bus_rd(IDX_PSCNT, 0, "R3 prescale under hold");

      // R4 reset-on-match slot 1 at 4: count = clocks mod 5
      bus_wr(IDX_PSC, 0);
      bus_wr(IDX_MATCH0 + 1, 4);
      bus_wr(IDX_MCTL, 32'h10);
      bus_wr(IDX_CTRL, 1);
      idle(12);
      bus_rd(IDX_COUNT, 2, "R4 wrap at match");
      bus_rd(IDX_IRQ, 0, "R6 no flag without irq bit");
      bus_wr(IDX_CTRL, 2);
      idle(2);

      // R5/R6 slot 0 stop+irq at 6, prescale 3
      bus_wr(IDX_PSC, 3);
      bus_wr(IDX_MATCH0, 6);
      bus_wr(IDX_MCTL, 32'h5);
      bus_wr(IDX_CTRL, 1);
      idle(40);
      bus_rd(IDX_COUNT, 6, "R5 count held at match");
      bus_rd(IDX_CTRL, 0, "R5 run bit cleared");
      bus_rd(IDX_IRQ, 1, "R6 match flag 0");
      chk("R6 irq line", 32'(irq), 1);

      // R7 write-one-to-clear
      bus_wr(IDX_IRQ, 0);
      bus_rd(IDX_IRQ, 1, "R7 write zero keeps flag");
      bus_wr(IDX_IRQ, 1);
      bus_rd(IDX_IRQ, 0, "R7 write one clears flag");
      chk("R7 irq line low", 32'(irq), 0);

      // R8 output actions: m0 low@1, m1 high@2, m2 invert+stop@3
      bus_wr(IDX_CTRL, 2);
      bus_wr(IDX_PSC, 0);
      bus_wr(IDX_MATCH0 + 0, 1);
      bus_wr(IDX_MATCH0 + 1, 2);
      bus_wr(IDX_MATCH0 + 2, 3);
      bus_wr(IDX_MCTL, 32'h100);
      bus_wr(I_EXT, 32'h399);
      chk("R8 written levels", 32'(ext_out), 32'h9);
      bus_wr(IDX_CTRL, 1);
      idle(10);
      chk("R8 levels after hits", 32'(ext_out), 32'hE);
      bus_rd(I_EXT, 32'h39E, "R8 ext word");
      bus_rd(IDX_COUNT, 3, "R5 stopped at slot 2");

      // R12 count word is read-only
      bus_wr(IDX_COUNT, 32'h55);
      bus_rd(IDX_COUNT, 3, "R12 count write ignored");

      // R9/R10 capture: ch0 rise+irq, ch1 fall only
      bus_wr(I_CCTL, 32'h15);
      cap_in[0] = 1'b1;
      idle(6);
      bus_rd(I_CAP0, 3, "R9 ch0 rising capture");
      bus_rd(IDX_IRQ, 32'h10, "R10 ch0 flag");
      cap_in[1] = 1'b1;
      idle(6);
      bus_rd(I_CAP1, 0, "R9 ch1 ignores rising");
      cap_in[1] = 1'b0;
      idle(6);
      bus_rd(I_CAP1, 3, "R9 ch1 falling capture");
      bus_rd(IDX_IRQ, 32'h10, "R10 ch1 no flag");
      bus_wr(IDX_IRQ, 32'h10);
      cap_in[0] = 1'b0;
      idle(6);
      bus_rd(IDX_IRQ, 0, "R10 ch0 fall ignored");

      // R11 edge counting: rising edges on input 1
      bus_wr(I_CCTL, 0);
      bus_wr(IDX_MCTL, 0);
      bus_wr(I_EXT, 0);
      bus_wr(IDX_PSC, 5);
      bus_wr(IDX_CTRL, 2);
      bus_wr(I_MODE, 5);
      bus_wr(IDX_CTRL, 1);
      for (int i = 0; i < 3; i++) pulse(1);
      for (int i = 0; i < 2; i++) pulse(0);
      bus_rd(IDX_COUNT, 3, "R11 rising edges of input 1");

      // R11 both edges on input 0
      bus_wr(IDX_CTRL, 2);
      bus_wr(I_MODE, 3);
      bus_wr(IDX_CTRL, 1);
      for (int i = 0; i < 2; i++) pulse(0);
      bus_rd(IDX_COUNT, 4, "R11 both edges of input 0");

      // R3 hold beats edges
      bus_wr(IDX_CTRL, 3);
      idle(2);
      pulse(0);
      bus_rd(IDX_COUNT, 0, "R3 hold with edges");

      // R12 map
      bus_rd(20, 0, "R12 reserved word");
      bus_rd(I_MODE, 3, "R12 source word");
      bus_rd(IDX_PSC, 5, "R12 prescale word");

      idle(3);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule